// File: doc/BRIEF.md
# Double-Buffered Clocked Serial Slave Port

This block is the slave side of a clock-synchronous serial link. An external master supplies the serial clock. Each frame carries 8 bits in each direction at once, least significant bit first. Outgoing bits change after a falling serial-clock edge. Incoming bits are sampled on the rising edge.

The host side sees one holding buffer in front of a shift register. A host write lands in the transmit holding register, and the shift core copies it in whenever a frame slot opens. A completed frame leaves its received byte in a read register.

The slave re-arms itself as soon as a frame ends, so the master may start the next frame at any time. Re-arming raises a one-cycle start pulse. Until the first falling serial edge of that frame, the host may still overwrite the byte that will go out. A one-cycle end pulse marks each finished frame.

The serial clock and data pins are synchronised into the system clock domain, and edges are detected there.

Top module: `sync_serial_slave`

## Requirements
- R1: After reset, `start_irq`, `end_irq`, `txbuf_full`, `tx_busy`, `rx_busy` and `rxbuf_full` are all 0 and `sdata_out` is 1.
- R2: Transmission is LSB first. After the k-th falling edge of `sclk_in` in a frame (k = 1..8), `sdata_out` carries bit k-1 of the frame's byte. That bit stays valid through the k-th rising edge.
- R3: On each rising edge, `sdata_in` is sampled, LSB first. After the 8th rising edge, `rd_data` holds the received byte, `rxbuf_full` is 1, and `end_irq` pulses high for exactly one clock cycle.
- R4: While `enable` is 1 and no frame is armed or shifting, the core loads the holding buffer and pulses `start_irq` for one cycle. This happens on enabling and in the cycle after each `end_irq`.
- R5: A write made after `start_irq` but before the frame's first falling edge replaces the byte that will be sent. The last such write is sent, and `txbuf_full` stays 0.
- R6: A write while the port is disabled or while a frame is shifting sets `txbuf_full` to 1. The flag holds until the byte is copied into the shift register at the next arming, which clears it. That byte is sent in the next frame.
- R7: `tx_busy` is 1 from the first falling edge of a frame until the frame ends. `rx_busy` is 1 from the first rising edge until the frame ends. Both are 0 while a frame is armed.
- R8: A one-cycle `rd_en` clears `rxbuf_full`. If a frame completes in the same cycle, the set wins.
- R9: While `enable` is 0, a partial frame is dropped and the bit count returns to zero. Serial edges are ignored, `tx_busy`, `rx_busy` and `rxbuf_full` are 0, and `sdata_out` is 1. A pending byte in the holding buffer is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Port enable; 0 aborts and holds the port idle |
| wr_en | input | 1 | One-cycle host write strobe for the transmit buffer |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | One-cycle strobe acknowledging the received byte |
| rd_data | output | 8 | Last received byte |
| sclk_in | input | 1 | Serial clock from the master, idle high |
| sdata_in | input | 1 | Serial data from the master |
| sdata_out | output | 1 | Serial data to the master |
| start_irq | output | 1 | One-cycle pulse when a frame is armed |
| end_irq | output | 1 | One-cycle pulse when a frame completes |
| txbuf_full | output | 1 | Holding buffer has a byte not yet taken |
| tx_busy | output | 1 | Transmit shifting in progress |
| rx_busy | output | 1 | Receive sampling in progress |
| rxbuf_full | output | 1 | Unacknowledged received byte present |

## Verification
The bench builds the block with its defaults: an 8-bit frame and two synchroniser stages. The serial clock runs at one sixteenth of the system clock.

With those values, all 256 transmit bytes can be streamed back to back. Each next byte is written in the middle of the frame before it, and a distinct receive pattern is paired with every frame. This covers both directions of the data path and the hand-off from holding buffer to shift register for every value.

Directed passes then cover the overwrite window between arming and the first edge, and an abort after three bits followed by a clean restart.

// File: rtl/ssp_pkg.sv
// Shared definitions for the serial slave port.
// Assumes: nothing beyond IEEE 1800-2017.
package ssp_pkg;
    // Frame slot state of the shift core.
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,   // nothing loaded; will load when enabled
        FS_ARMED = 2'd1,   // byte loaded, waiting for first falling edge
        FS_SHIFT = 2'd2    // frame in progress
    } frame_state_t;
endpackage

// File: rtl/ssp_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes: STAGES >= 2; inputs change slower than clk/4 so no edge is lost.
module ssp_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= {stage_q[STAGES-2:0], async_in};
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/ssp_shift_core.sv
// Frame shift engine: arms a byte, shifts it out on falling serial edges,
// samples input on rising edges, and signals frame start and end.
// Assumes: rise/fall are single-cycle pulses in the clk domain, never together.
module ssp_shift_core
    import ssp_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               din,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               arm_wr,
    input  logic [FRAME_W-1:0] arm_word,
    output logic               dout,
    output logic               start_pulse,
    output logic               done_pulse,
    output logic               shifting,
    output logic               rx_active,
    output logic               armed,
    output logic               loading,
    output logic               frame_last,
    output logic [FRAME_W-1:0] rx_word
);
    localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    frame_state_t       state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] txsh_q;
    logic [FRAME_W-1:0] rxsh_q;

    // Decode the slot state for the surrounding buffer logic.
    assign shifting   = (state_q == FS_SHIFT);
    assign armed      = (state_q == FS_ARMED);
    assign loading    = enable && (state_q == FS_IDLE);
    assign frame_last = enable && shifting && sclk_rise && (cnt_q == LAST_BIT);
    assign rx_word    = {din, rxsh_q[FRAME_W-1:1]};

    // Sequence arming, bit shifting and frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= FS_IDLE;
            cnt_q       <= '0;
            txsh_q      <= '0;
            rxsh_q      <= '0;
            dout        <= 1'b1;
            start_pulse <= 1'b0;
            done_pulse  <= 1'b0;
            rx_active   <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            done_pulse  <= 1'b0;
            if (!enable) begin
                state_q   <= FS_IDLE;
                cnt_q     <= '0;
                dout      <= 1'b1;
                rx_active <= 1'b0;
            end else begin
                case (state_q)
                    FS_IDLE: begin
                        txsh_q      <= load_word;
                        state_q     <= FS_ARMED;
                        start_pulse <= 1'b1;
                    end
                    FS_ARMED: begin
                        if (sclk_fall) begin
                            dout    <= txsh_q[0];
                            txsh_q  <= txsh_q >> 1;
                            state_q <= FS_SHIFT;
                        end else if (arm_wr) begin
                            txsh_q <= arm_word;
                        end
                    end
                    FS_SHIFT: begin
                        if (sclk_fall) begin
                            dout   <= txsh_q[0];
                            txsh_q <= txsh_q >> 1;
                        end
                        if (sclk_rise) begin
                            rxsh_q <= rx_word;
                            if (cnt_q == LAST_BIT) begin
                                cnt_q      <= '0;
                                state_q    <= FS_IDLE;
                                done_pulse <= 1'b1;
                                rx_active  <= 1'b0;
                            end else begin
                                cnt_q     <= cnt_q + 1'b1;
                                rx_active <= 1'b1;
                            end
                        end
                    end
                    default: state_q <= FS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sync_serial_slave.sv
// Double-buffered clock-synchronous serial slave (8-bit, LSB first,
// data out on falling edge, data in on rising edge, serial clock idles high).
// Assumes: clk runs at least 4x the serial clock; host strobes are one cycle.
module sync_serial_slave #(
    parameter int FRAME_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic               rd_en,
    output logic [FRAME_W-1:0] rd_data,
    input  logic               sclk_in,
    input  logic               sdata_in,
    output logic               sdata_out,
    output logic               start_irq,
    output logic               end_irq,
    output logic               txbuf_full,
    output logic               tx_busy,
    output logic               rx_busy,
    output logic               rxbuf_full
);
    localparam int PIN_N = 2;
    localparam logic [PIN_N-1:0] PIN_IDLE = 2'b01;   // bit0 sclk idles high

    logic [PIN_N-1:0]   pins_s;
    logic               sclk_prev_q;
    logic               sclk_rise, sclk_fall;
    logic [FRAME_W-1:0] txbuf_q, rxbuf_q, rx_word;
    logic               txfull_q, rxfull_q;
    logic               armed, loading, frame_last, arm_wr;

    ssp_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({sdata_in, sclk_in}),
        .sync_out(pins_s)
    );

    // Remember the previous synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b1;
        else        sclk_prev_q <= pins_s[0];
    end

    assign sclk_rise = pins_s[0] & ~sclk_prev_q;
    assign sclk_fall = ~pins_s[0] & sclk_prev_q;
    assign arm_wr    = wr_en && enable && armed && !sclk_fall;

    ssp_shift_core #(.FRAME_W(FRAME_W)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .din        (pins_s[1]),
        .load_word  (txbuf_q),
        .arm_wr     (arm_wr),
        .arm_word   (wr_data),
        .dout       (sdata_out),
        .start_pulse(start_irq),
        .done_pulse (end_irq),
        .shifting   (tx_busy),
        .rx_active  (rx_busy),
        .armed      (armed),
        .loading    (loading),
        .frame_last (frame_last),
        .rx_word    (rx_word)
    );

    // Transmit holding buffer and its full flag (write beats load).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txbuf_q  <= '0;
            txfull_q <= 1'b0;
        end else begin
            if (wr_en) txbuf_q <= wr_data;
            if (wr_en && !arm_wr) txfull_q <= 1'b1;
            else if (loading)     txfull_q <= 1'b0;
        end
    end

    // Receive buffer and its full flag (frame end beats host read).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxbuf_q  <= '0;
            rxfull_q <= 1'b0;
        end else if (!enable) begin
            rxfull_q <= 1'b0;
        end else if (frame_last) begin
            rxbuf_q  <= rx_word;
            rxfull_q <= 1'b1;
        end else if (rd_en) begin
            rxfull_q <= 1'b0;
        end
    end

    assign txbuf_full = txfull_q;
    assign rxbuf_full = rxfull_q;
    assign rd_data    = rxbuf_q;
endmodule

// File: rtl/ssp_checker.sv
// Temporal checks on the serial slave port outputs; bound to the top.
// Assumes: synchronous active-low reset on rst_n.
module ssp_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic start_irq,
    input logic end_irq,
    input logic tx_busy,
    input logic rx_busy,
    input logic rxbuf_full,
    input logic sdata_out
);
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_irq |=> !start_irq);

    p_end_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |=> !end_irq);

    p_end_fills_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |-> rxbuf_full);

    p_rearm_after_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (end_irq && enable) |=> start_irq);

    p_armed_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_irq |-> (!tx_busy && !rx_busy));

    p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!tx_busy && !rx_busy && !rxbuf_full && sdata_out));
endmodule

bind sync_serial_slave ssp_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .start_irq (start_irq),
    .end_irq   (end_irq),
    .tx_busy   (tx_busy),
    .rx_busy   (rx_busy),
    .rxbuf_full(rxbuf_full),
    .sdata_out (sdata_out)
);

// File: tb/sync_serial_slave_tb_top.sv
`timescale 1ns/1ps
// Bench: streams all 256 bytes through the port acting as serial master,
// then covers the overwrite window and an abort/restart.
module sync_serial_slave_tb_top;
    localparam int HALF = 8;   // system clocks per serial half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       sclk_in = 1'b1;
    logic       sdata_in = 1'b0;
    logic       sdata_out, start_irq, end_irq;
    logic       txbuf_full, tx_busy, rx_busy, rxbuf_full;

    int checks = 0;
    int errors = 0;
    int n_start = 0;
    int n_end = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    sync_serial_slave dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .sclk_in(sclk_in), .sdata_in(sdata_in), .sdata_out(sdata_out),
        .start_irq(start_irq), .end_irq(end_irq), .txbuf_full(txbuf_full),
        .tx_busy(tx_busy), .rx_busy(rx_busy), .rxbuf_full(rxbuf_full)
    );

    // Count interrupt pulses.
    always @(posedge clk) begin
        if (start_irq) n_start <= n_start + 1;
        if (end_irq)   n_end   <= n_end + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    // One master frame; optional host write in the middle of the frame.
    task automatic frame(input logic [7:0] mosi, input bit mid_wr,
                         input logic [7:0] mid_val, output logic [7:0] miso);
        for (int i = 0; i < 8; i++) begin
            sclk_in = 1'b0; sdata_in = mosi[i];
            clks(HALF);
            miso[i] = sdata_out;
            if (i == 3) begin
                chk("R7 tx_busy mid-frame", tx_busy, 1);
                chk("R7 rx_busy mid-frame", rx_busy, 1);
            end
            sclk_in = 1'b1;
            clks(HALF);
            if (mid_wr && i == 4) begin
                host_write(mid_val);
                chk("R6 txbuf_full after mid-frame write", txbuf_full, 1);
            end
        end
        clks(6);
    endtask

    initial begin
        logic [7:0] got, mosi;
        int s0, e0;
        clks(4);
        rst_n = 1'b1;
        clks(2);
        // R1 reset state
        chk("R1 start_irq", start_irq, 0);
        chk("R1 end_irq", end_irq, 0);
        chk("R1 flags", {txbuf_full, tx_busy, rx_busy, rxbuf_full}, 0);
        chk("R1 sdata_out", sdata_out, 1);

        // R6 write while disabled, then enable arms it (R4)
        host_write(8'h00);
        chk("R6 txbuf_full while disabled", txbuf_full, 1);
        s0 = n_start;
        enable = 1'b1;
        clks(3);
        chk("R4 start on enable", n_start - s0, 1);
        chk("R6 txbuf_full cleared by load", txbuf_full, 0);
        chk("R7 busy low while armed", {tx_busy, rx_busy}, 0);

        // Sweep all 256 transmit values, streamed with mid-frame writes
        for (int k = 0; k < 256; k++) begin
            mosi = 8'((k * 37 + 11) & 8'hFF);
            s0 = n_start; e0 = n_end;
            frame(mosi, 1'b1, 8'((k + 1) & 8'hFF), got);
            chk("R2 transmitted byte", got, k[7:0]);
            chk("R3 received byte", rd_data, mosi);
            chk("R3 rxbuf_full at end", rxbuf_full, 1);
            chk("R3 one end pulse", n_end - e0, 1);
            chk("R4 re-arm start pulse", n_start - s0, 1);
            chk("R6 txbuf_full cleared at re-arm", txbuf_full, 0);
            host_read();
            chk("R8 rxbuf_full cleared by read", rxbuf_full, 0);
        end

        // Frame sending the last pending byte (0), no mid write
        frame(8'h42, 1'b0, 8'h00, got);
        chk("R2 last pending byte", got, 8'h00);
        // R5 overwrite window after start, before first falling edge
        host_write(8'h11);
        clks(2);
        host_write(8'h3C);
        chk("R5 txbuf_full stays low", txbuf_full, 0);
        frame(8'hC3, 1'b0, 8'h00, got);
        chk("R5 last written byte sent", got, 8'h3C);
        chk("R3 received C3", rd_data, 8'hC3);

        // R9 abort after three bits
        for (int i = 0; i < 3; i++) begin
            sclk_in = 1'b0; sdata_in = 1'b1; clks(HALF);
            sclk_in = 1'b1; clks(HALF);
        end
        chk("R7 busy before abort", {tx_busy, rx_busy}, 2'b11);
        enable = 1'b0;
        clks(2);
        chk("R9 busy cleared", {tx_busy, rx_busy}, 0);
        chk("R9 rxbuf_full cleared", rxbuf_full, 0);
        chk("R9 sdata_out idle", sdata_out, 1);
        e0 = n_end;
        for (int i = 0; i < 2; i++) begin
            sclk_in = 1'b0; clks(HALF);
            sclk_in = 1'b1; clks(HALF);
        end
        chk("R9 edges ignored while disabled", {n_end - e0, 24'(0), tx_busy, rx_busy}, 0);
        host_write(8'h96);
        s0 = n_start;
        enable = 1'b1;
        clks(3);
        chk("R4 start on re-enable", n_start - s0, 1);
        e0 = n_end;
        frame(8'h5B, 1'b0, 8'h00, got);
        chk("R9 restart sends pending byte", got, 8'h96);
        chk("R9 restart receives full byte", rd_data, 8'h5B);
        chk("R9 one end after restart", n_end - e0, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule